// File: doc/BRIEF.md
# Width-Selectable Receive Packing FIFO

This block sits between a serial receiver that delivers one character per cycle and the logic that writes received data into memory buffers. A single storage array serves two ways of working. In word mode, incoming bytes are gathered into 32-bit words, and a word is offered on the output only once four bytes are present or the frame has ended. In byte mode, each character is offered on the output the cycle after it arrives, and each storage slot holds one byte. Byte mode is the choice for character-oriented links that need low latency. Word mode is the choice for frame-oriented links that need throughput.

The parameter `LARGE_CHAN` sets the size of the array. A large channel holds 32 bytes in word mode and 8 bytes in byte mode. A small channel holds 16 bytes in word mode and 4 bytes in byte mode. A byte arriving while the array is full is lost, and a sticky error flag records the loss. A mode request takes effect only while the block holds no data. Until then the request waits.

Top module: `rx_pack_fifo`

## Requirements
- R1: After reset, `empty_o`=1, `full_o`=0, `out_valid_o`=0, `overrun_o`=0, and the active mode `mode_o`=0 (word mode).
- R2: In word mode, four non-final bytes form one output word. The first byte received sits in bits 31:24 and the fourth in bits 7:0. `out_count_o`=4 and `out_eof_o`=0. The word becomes valid in the cycle after the fourth byte is captured.
- R3: In word mode, while fewer than four bytes of an unfinished word have arrived, `out_valid_o` stays 0 and `empty_o` is 0.
- R4: In word mode, a byte with `in_eof_i`=1 flushes the partial word. Its n bytes (1 to 4) fill the upper lanes in arrival order, and the unused lower lanes are zero. `out_count_o`=n and `out_eof_o`=1.
- R5: In byte mode (`mode_o`=1), each byte becomes valid in the cycle after capture, with the byte in bits 7:0, bits 31:8 zero, `out_count_o`=1, and `out_eof_o` equal to its `in_eof_i`.
- R6: `full_o` rises once the array holds its capacity: 32 bytes (large) or 16 bytes (small) as words in word mode, and 8 or 4 single bytes in byte mode.
- R7: A byte presented while `full_o`=1 is dropped and never appears on the output. It sets `overrun_o`, which stays 1 until `overrun_clr_i` is pulsed. A drop in the same cycle as a clear wins.
- R8: `mode_o` takes the value of `byte_mode_i` only at a clock edge where `empty_o`=1 and `in_valid_i`=0. Otherwise the requested change is deferred.
- R9: While `out_valid_o`=1 and `out_ready_i`=0, the output entry is held stable. Entries leave in arrival order, one per cycle in which `out_valid_o` and `out_ready_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_mode_i | input | 1 | Requested mode: 0 word, 1 byte |
| in_valid_i | input | 1 | A received byte is present |
| in_data_i | input | 8 | Received byte |
| in_eof_i | input | 1 | This byte ends the frame |
| out_valid_o | output | 1 | Output entry available |
| out_ready_i | input | 1 | Consumer takes the entry |
| out_data_o | output | 32 | Packed word or byte in bits 7:0 |
| out_count_o | output | 3 | Number of valid bytes, 1 to 4 |
| out_eof_o | output | 1 | Entry closes a frame |
| full_o | output | 1 | Array at capacity |
| empty_o | output | 1 | No stored or partially packed data |
| overrun_o | output | 1 | Sticky dropped-byte flag |
| overrun_clr_i | input | 1 | Clears the overrun flag |
| mode_o | output | 1 | Active mode |

## Verification
The bench builds the block with `LARGE_CHAN` = 0, which gives four slots. The full condition is then reached after 16 bytes in word mode and after 4 bytes in byte mode. This keeps the dropped-byte path and the sticky flag within a short run. The default large-channel value differs only in array depth, and it is covered by elaboration of the RTL.

// File: rtl/rxpf_pkg.sv
package rxpf_pkg;
    // One stored slot: packed data, number of valid bytes, frame end marker.
    typedef struct packed {
        logic [31:0] data;
        logic [2:0]  cnt;
        logic        eof;
    } rxpf_entry_t;
endpackage

// File: rtl/rxpf_packer.sv
module rxpf_packer
    import rxpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_mode_i,
    input  logic        push_i,
    input  logic [7:0]  data_i,
    input  logic        eof_i,
    output logic        wr_en_o,
    output rxpf_entry_t wr_entry_o,
    output logic        busy_o
);
    typedef struct packed {
        logic [31:0] acc;
        logic [2:0]  fill;
    } pack_state_t;

    pack_state_t st_q, st_d;
    logic [31:0] merged;
    logic [2:0]  fill_n;

    always_comb begin
        st_d       = st_q;
        wr_en_o    = 1'b0;
        wr_entry_o = '0;
        merged     = st_q.acc | ({data_i, 24'h0} >> {st_q.fill, 3'b000});
        fill_n     = st_q.fill + 3'd1;
        if (push_i) begin
            if (byte_mode_i) begin
                wr_en_o    = 1'b1;
                wr_entry_o = '{data: {24'h0, data_i}, cnt: 3'd1, eof: eof_i};
            end else if (fill_n == 3'd4 || eof_i) begin
                wr_en_o    = 1'b1;
                wr_entry_o = '{data: merged, cnt: fill_n, eof: eof_i};
                st_d       = '0;
            end else begin
                st_d.acc  = merged;
                st_d.fill = fill_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.fill != 3'd0);

    // A partial word never waits in the packer while byte mode is active.
    p_no_partial_in_byte_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode_i |-> !busy_o);
endmodule

// File: rtl/rxpf_store.sv
module rxpf_store
    import rxpf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  rxpf_entry_t wr_entry_i,
    input  logic        rd_en_i,
    output rxpf_entry_t rd_entry_o,
    output logic        full_o,
    output logic        empty_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [AW:0]   used;
    } store_state_t;

    store_state_t st_q, st_d;
    rxpf_entry_t  slots [DEPTH];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        if (rd_en_i) st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        case ({wr_en_i, rd_en_i})
            2'b10:   st_d.used = st_q.used + 1'b1;
            2'b01:   st_d.used = st_q.used - 1'b1;
            default: st_d.used = st_q.used;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) slots[st_q.wr_ptr] <= wr_entry_i;
    end

    assign rd_entry_o = slots[st_q.rd_ptr];
    assign full_o     = (st_q.used == (AW+1)'(DEPTH));
    assign empty_o    = (st_q.used == '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !full_o);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |-> !empty_o);
endmodule

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo
    import rxpf_pkg::*;
#(
    parameter bit LARGE_CHAN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_mode_i,
    input  logic        in_valid_i,
    input  logic [7:0]  in_data_i,
    input  logic        in_eof_i,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic [31:0] out_data_o,
    output logic [2:0]  out_count_o,
    output logic        out_eof_o,
    output logic        full_o,
    output logic        empty_o,
    output logic        overrun_o,
    input  logic        overrun_clr_i,
    output logic        mode_o
);
    localparam int WIDE_BYTES = LARGE_CHAN ? 32 : 16;
    localparam int SLOTS      = WIDE_BYTES / 4;   // words in word mode, bytes in byte mode

    typedef struct packed {
        logic mode;
        logic ovr;
    } ctl_state_t;

    ctl_state_t  ctl_q, ctl_d;
    logic        accept, drop, store_full, store_empty, pk_busy, wr_en;
    rxpf_entry_t wr_entry, rd_entry;

    assign accept = in_valid_i && !store_full;
    assign drop   = in_valid_i && store_full;

    rxpf_packer u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_mode_i(ctl_q.mode),
        .push_i     (accept),
        .data_i     (in_data_i),
        .eof_i      (in_eof_i),
        .wr_en_o    (wr_en),
        .wr_entry_o (wr_entry),
        .busy_o     (pk_busy)
    );

    rxpf_store #(.DEPTH(SLOTS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_entry_i(wr_entry),
        .rd_en_i   (out_valid_o && out_ready_i),
        .rd_entry_o(rd_entry),
        .full_o    (store_full),
        .empty_o   (store_empty)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (drop)               ctl_d.ovr = 1'b1;
        else if (overrun_clr_i) ctl_d.ovr = 1'b0;
        if (empty_o && !in_valid_i) ctl_d.mode = byte_mode_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign out_valid_o = !store_empty;
    assign out_data_o  = rd_entry.data;
    assign out_count_o = rd_entry.cnt;
    assign out_eof_o   = rd_entry.eof;
    assign full_o      = store_full;
    assign empty_o     = store_empty && !pk_busy;
    assign overrun_o   = ctl_q.ovr;
    assign mode_o      = ctl_q.mode;

    p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_count_o >= 3'd1 && out_count_o <= 3'd4));
    p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && mode_o) |-> (out_count_o == 3'd1 && out_data_o[31:8] == 24'h0));
    p_mode_deferred_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_o |=> $stable(mode_o));
    p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && full_o) |=> overrun_o);
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !overrun_clr_i) |=> overrun_o);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
                                           && $stable(out_count_o) && $stable(out_eof_o)));
endmodule

// File: tb/rx_pack_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_pack_fifo_tb_top;
    localparam bit TB_LARGE = 1'b0;
    localparam int SLOTS    = TB_LARGE ? 8 : 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0, in_valid = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        out_ready = 1'b0, ovr_clr = 1'b0;
    logic        out_valid, out_eof, full, empty, overrun, mode;
    logic [31:0] out_data;
    logic [2:0]  out_count;

    always #2 clk = ~clk;

    rx_pack_fifo #(.LARGE_CHAN(TB_LARGE)) dut_i (
        .clk(clk), .rst_n(rst_n), .byte_mode_i(byte_mode),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_eof_i(in_eof),
        .out_valid_o(out_valid), .out_ready_i(out_ready),
        .out_data_o(out_data), .out_count_o(out_count), .out_eof_o(out_eof),
        .full_o(full), .empty_o(empty), .overrun_o(overrun),
        .overrun_clr_i(ovr_clr), .mode_o(mode)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] q_data [$];
    logic [2:0]  q_cnt  [$];
    logic        q_eof  [$];
    string       q_tag  [$];

    bit          m_byte = 1'b0;
    logic [31:0] m_acc  = '0;
    int          m_fill = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [31:0] d, input logic [2:0] c, input logic e,
                            input string tag);
        q_data.push_back(d); q_cnt.push_back(c); q_eof.push_back(e); q_tag.push_back(tag);
    endtask

    // Driver: present one byte for one cycle and update the reference model.
    task automatic send(input logic [7:0] d, input bit eof, input bit dropped, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = d; in_eof = eof;
        @(posedge clk); #1;
        in_valid = 1'b0; in_eof = 1'b0;
        if (!dropped) begin
            if (m_byte) push_exp({24'h0, d}, 3'd1, eof, tag);
            else begin
                m_acc[31-8*m_fill -: 8] = d;
                m_fill++;
                if (m_fill == 4 || eof) begin
                    push_exp(m_acc, 3'(m_fill), eof, tag);
                    m_acc = '0; m_fill = 0;
                end
            end
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain(input string tag);
        out_ready = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (empty && q_data.size() == 0) break;
            wait_cyc(1);
        end
        check(empty && q_data.size() == 0, tag, "drain empty", {35'h0, empty}, 36'h1);
        out_ready = 1'b0;
    endtask

    // Monitor: compare each transferred entry with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R9", "unexpected entry", {out_data, out_count, out_eof}, 36'h0);
            end else begin
                automatic logic [35:0] expv = {q_data[0], q_cnt[0], q_eof[0]};
                automatic string t = q_tag[0];
                void'(q_data.pop_front()); void'(q_cnt.pop_front());
                void'(q_eof.pop_front());  void'(q_tag.pop_front());
                check({out_data, out_count, out_eof} == expv, t, "scoreboard entry",
                      {out_data, out_count, out_eof}, expv);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        check(empty == 1 && full == 0 && out_valid == 0, "R1", "flags after reset",
              {33'h0, empty, full, out_valid}, 36'h4);
        check(overrun == 0 && mode == 0, "R1", "overrun/mode after reset",
              {34'h0, overrun, mode}, 36'h0);

        // R3 / R2: word packing
        send(8'hA1, 0, 0, "R2"); send(8'hA2, 0, 0, "R2"); send(8'hA3, 0, 0, "R2");
        check(out_valid == 0, "R3", "no output before four bytes", {35'h0, out_valid}, 36'h0);
        check(empty == 0, "R3", "partial word counts as data", {35'h0, empty}, 36'h0);
        send(8'hA4, 0, 0, "R2");
        check(out_valid == 1 && out_data == 32'hA1A2A3A4 && out_count == 3'd4,
              "R2", "packed word", {out_valid, out_data, out_count}, {1'b1, 32'hA1A2A3A4, 3'd4});
        held = out_data;
        wait_cyc(3);
        check(out_valid == 1 && out_data == held, "R9", "held under backpressure",
              {3'h0, out_valid, out_data}, {3'h0, 1'b1, held});
        drain("R2");

        // R4: end-of-frame flushes
        send(8'hB1, 0, 0, "R4"); send(8'hB2, 1, 0, "R4");
        send(8'hC1, 1, 0, "R4");
        send(8'hD1, 0, 0, "R4"); send(8'hD2, 0, 0, "R4"); send(8'hD3, 0, 0, "R4");
        send(8'hD4, 1, 0, "R4");
        drain("R4");

        // R6 / R7: fill in word mode, then overrun
        for (int i = 0; i < 4 * SLOTS; i++) send(8'(8'h10 + i), 0, 0, "R9");
        check(full == 1, "R6", "full after word capacity", {35'h0, full}, 36'h1);
        send(8'hEE, 0, 1, "R7");
        check(overrun == 1, "R7", "overrun set on drop", {35'h0, overrun}, 36'h1);
        drain("R7");
        check(overrun == 1, "R7", "overrun sticky", {35'h0, overrun}, 36'h1);
        ovr_clr = 1'b1; wait_cyc(1); ovr_clr = 1'b0; wait_cyc(1);
        check(overrun == 0, "R7", "overrun cleared", {35'h0, overrun}, 36'h0);

        // R8: mode change deferred while data is held
        send(8'hE1, 0, 0, "R8"); send(8'hE2, 0, 0, "R8");
        byte_mode = 1'b1;
        wait_cyc(3);
        check(mode == 0, "R8", "mode held with partial word", {35'h0, mode}, 36'h0);
        send(8'hE3, 1, 0, "R8");
        wait_cyc(2);
        check(mode == 0, "R8", "mode held with stored word", {35'h0, mode}, 36'h0);
        drain("R8");
        wait_cyc(2);
        check(mode == 1, "R8", "mode switched after drain", {35'h0, mode}, 36'h1);
        m_byte = 1'b1;

        // R5: byte mode delivery
        out_ready = 1'b1;
        for (int i = 0; i < 5; i++) send(8'(8'h50 + i), i == 4, 0, "R5");
        drain("R5");
        send(8'h61, 0, 0, "R5");
        check(out_valid == 1 && out_data == 32'h61 && out_count == 3'd1,
              "R5", "byte available next cycle", {out_valid, out_data, out_count},
              {1'b1, 32'h61, 3'd1});
        for (int i = 1; i < SLOTS; i++) send(8'(8'h61 + i), 0, 0, "R5");
        check(full == 1, "R6", "full after byte capacity", {35'h0, full}, 36'h1);
        send(8'h77, 1, 1, "R7");
        check(overrun == 1, "R7", "byte-mode drop flags overrun", {35'h0, overrun}, 36'h1);
        ovr_clr = 1'b1;
        send(8'h78, 0, 1, "R7");
        ovr_clr = 1'b0;
        check(overrun == 1, "R7", "drop wins over clear", {35'h0, overrun}, 36'h1);
        drain("R7");

        byte_mode = 1'b0;
        wait_cyc(2);
        check(mode == 0, "R8", "back to word mode when empty", {35'h0, mode}, 36'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule